// File: doc/BRIEF.md
# Second Sound Channel: Tone, Noise and Alarm Envelope

This block is the second voice of a small programmable sound generator. A single 15-bit state machine is shared by three uses, and two mode bits choose the use. In tone mode a 7-bit divider, loaded from the top seven bits of the channel's period register, produces a square wave. In noise mode a maximal-length 15-bit linear feedback shift register produces wide-band noise. In alarm mode the channel makes a slow 50% envelope that switches the first channel's tone on and off.

Two clock enables drive the channel. The shared PSG tick advances the tone divider and the noise register, either on every tick or on every eighth tick depending on the octave bit. A 64 Hz slow tick sets the timing of the envelope. When the channel enable is low, the channel is silent and its state is restarted.

Top module: `sc2_noise_channel`

## Requirements
- R1: Mode decode. `alarm_sel`=1 selects alarm mode whatever the value of `noise_sel`. `noise_sel`=1 with `alarm_sel`=0 selects noise mode. Both bits at 0 select tone mode.
- R2: In tone mode `ch_out` is a square wave that toggles once every (128 - N) steps, where N = `div_reg[14:8]`. Bits `div_reg[7:0]` have no effect on the tone.
- R3: With `octave_sel`=0 each PSG tick is one step. With `octave_sel`=1 one step happens per eight PSG ticks.
- R4: In noise mode each step shifts the register left and feeds `bit14 XOR bit13` into bit 0 (polynomial x^15+x^14+1). `ch_out` then shows that new bit 0. Enabling the channel starts the register from the seed 15'h0001.
- R5: The noise register never holds all zeros.
- R6: In alarm mode `env_gate` is a 50% square wave whose rate is set by `div_reg[1:0]`: 00 gives 1 Hz (32 slow ticks per half period), 01 gives 4 Hz (8 ticks), 10 gives 8 Hz (4 ticks) and 11 gives 32 Hz (1 tick). `env_gate` changes only on a slow tick.
- R7: In alarm mode `ch_out` equals `tone_in` AND the envelope. It is therefore low whenever `tone_in` is low.
- R8: `env_gate` stays low in tone mode and in noise mode.
- R9: One cycle after `chan_en` goes low, both outputs are low. The noise register is then reseeded and the tone divider reloaded.
- R10: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psg_tick | input | 1 | Shared PSG clock enable, one cycle wide |
| slow_tick | input | 1 | 64 Hz enable pulse for the envelope |
| chan_en | input | 1 | Channel enable |
| octave_sel | input | 1 | 1: one step per eight PSG ticks |
| div_reg | input | 15 | Period register |
| noise_sel | input | 1 | Mode bit belonging to this channel |
| alarm_sel | input | 1 | Mode bit belonging to the tone channel (alarm select) |
| tone_in | input | 1 | Output of the tone channel, gated in alarm mode |
| ch_out | output | 1 | Registered channel output |
| env_gate | output | 1 | Registered alarm envelope |

## Verification
The bench builds the channel with its default parameters: a 15-bit register, a 7-bit tone field, a prescale of eight and a 64 Hz slow tick. With these values all four envelope rates fit in short runs, since the slowest half period is 32 slow ticks. The PSG tick and the slow tick are driven every few clock cycles rather than at audio rates, so tone periods at both octave settings and dozens of noise steps can be compared against a model of the polynomial written from R4. Re-enabling the channel in noise mode checks that the register is reseeded.

// File: rtl/sc2_pkg.sv
package sc2_pkg;
  typedef enum logic [1:0] {
    SC2_TONE  = 2'd0,
    SC2_NOISE = 2'd1,
    SC2_ALARM = 2'd2
  } sc2_mode_e;

  // Alarm select wins over the noise select.
  function automatic sc2_mode_e sc2_decode(input logic noise_bit, input logic alarm_bit);
    if (alarm_bit)      return SC2_ALARM;
    else if (noise_bit) return SC2_NOISE;
    else                return SC2_TONE;
  endfunction
endpackage

// File: rtl/sc2_step_gen.sv
module sc2_step_gen #(
  parameter int PRE_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic slow_mode,
  output logic step
);
  localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      step  <= 1'b0;
    end else begin
      step <= tick && (!slow_mode || cnt_q == LAST);
      if (tick) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc2_tone_div.sv
module sc2_tone_div #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         sq
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= reload;
      sq    <= 1'b0;
    end else if (step) begin
      if (&cnt_q) begin
        cnt_q <= reload;
        sq    <= ~sq;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc2_lfsr.sv
module sc2_lfsr #(
  parameter int           W     = 15,
  parameter logic [W-1:0] SEED  = 1,
  parameter int           TAP_A = 14,
  parameter int           TAP_B = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = state[TAP_A] ^ state[TAP_B];

  always_ff @(posedge clk) begin
    if (rst || clr)  state <= SEED;
    else if (step)   state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/sc2_envelope.sv
module sc2_envelope #(
  parameter int TICK_HZ = 64,
  parameter int RATE0   = 1,
  parameter int RATE1   = 4,
  parameter int RATE2   = 8,
  parameter int RATE3   = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] rate_sel,
  output logic       gate
);
  localparam int HMAX = TICK_HZ / (2 * RATE0);
  localparam int CW   = $clog2(HMAX + 1);
  localparam int NR   = 4;
  localparam int RATES [NR] = '{RATE0, RATE1, RATE2, RATE3};

  logic [CW-1:0] half_tbl [NR];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half;

  for (genvar g = 0; g < NR; g++) begin : g_half
    assign half_tbl[g] = CW'(TICK_HZ / (2 * RATES[g]));
  end

  assign half = half_tbl[rate_sel];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      gate  <= 1'b0;
    end else if (tick) begin
      if (cnt_q + 1'b1 >= half) begin
        cnt_q <= '0;
        gate  <= ~gate;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc2_noise_channel.sv
module sc2_noise_channel
  import sc2_pkg::*;
#(
  parameter int             W_LFSR  = 15,
  parameter int             W_TONE  = 7,
  parameter int             PRE_DIV = 8,
  parameter int             TICK_HZ = 64,
  parameter logic [W_LFSR-1:0] SEED = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psg_tick,
  input  logic              slow_tick,
  input  logic              chan_en,
  input  logic              octave_sel,
  input  logic [W_LFSR-1:0] div_reg,
  input  logic              noise_sel,
  input  logic              alarm_sel,
  input  logic              tone_in,
  output logic              ch_out,
  output logic              env_gate
);
  localparam int TONE_LO = W_LFSR - W_TONE;

  sc2_mode_e         mode;
  logic              step;
  logic              tone_sq;
  logic [W_LFSR-1:0] lfsr_q;

  assign mode = sc2_decode(noise_sel, alarm_sel);

  sc2_step_gen #(.PRE_DIV(PRE_DIV)) u_step (
    .clk(clk), .rst(rst), .clr(!chan_en), .tick(psg_tick),
    .slow_mode(octave_sel), .step(step)
  );

  sc2_tone_div #(.W(W_TONE)) u_tone (
    .clk(clk), .rst(rst), .clr(!chan_en || mode != SC2_TONE), .step(step),
    .reload(div_reg[W_LFSR-1:TONE_LO]), .sq(tone_sq)
  );

  sc2_lfsr #(.W(W_LFSR), .SEED(SEED), .TAP_A(W_LFSR-1), .TAP_B(W_LFSR-2)) u_lfsr (
    .clk(clk), .rst(rst), .clr(!chan_en), .step(step && mode == SC2_NOISE),
    .state(lfsr_q)
  );

  sc2_envelope #(.TICK_HZ(TICK_HZ)) u_env (
    .clk(clk), .rst(rst), .clr(!chan_en || mode != SC2_ALARM), .tick(slow_tick),
    .rate_sel(div_reg[1:0]), .gate(env_gate)
  );

  always_ff @(posedge clk) begin
    if (rst || !chan_en) begin
      ch_out <= 1'b0;
    end else begin
      unique case (mode)
        SC2_NOISE: ch_out <= lfsr_q[0];
        SC2_ALARM: ch_out <= tone_in && env_gate;
        default:   ch_out <= tone_sq;
      endcase
    end
  end
endmodule

// File: rtl/sc2_noise_channel_chk.sv
module sc2_noise_channel_chk #(
  parameter int W = 15
) (
  input logic         clk,
  input logic         rst,
  input logic         chan_en,
  input logic         alarm_sel,
  input logic         slow_tick,
  input logic         tone_in,
  input logic         ch_out,
  input logic         env_gate,
  input logic [W-1:0] lfsr_state
);
  a_r9_disable_silences: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> (!ch_out && !env_gate));

  a_r8_gate_only_in_alarm: assert property (@(posedge clk) disable iff (rst)
    env_gate |-> $past(chan_en && alarm_sel));

  a_r7_alarm_needs_tone: assert property (@(posedge clk) disable iff (rst)
    (chan_en && alarm_sel && !tone_in) |=> !ch_out);

  a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  a_r6_gate_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!$stable(env_gate) && $past(chan_en && alarm_sel)) |-> $past(slow_tick));
endmodule

bind sc2_noise_channel sc2_noise_channel_chk #(.W(W_LFSR)) chk_i (
  .clk(clk), .rst(rst), .chan_en(chan_en), .alarm_sel(alarm_sel),
  .slow_tick(slow_tick), .tone_in(tone_in), .ch_out(ch_out),
  .env_gate(env_gate), .lfsr_state(lfsr_q)
);

// File: tb/sc2_noise_channel_tb.sv
module sc2_noise_channel_tb_top;
  logic clk = 0, rst = 1;
  logic psg_tick = 0, slow_tick = 0, chan_en = 0, octave_sel = 0;
  logic [14:0] div_reg = '0;
  logic noise_sel = 0, alarm_sel = 0, tone_in = 0;
  logic ch_out, env_gate;

  int checks = 0, failures = 0, cyc = 0;
  int tick_per = 0, slow_per = 0;
  int exp_q[$];
  bit mon_en = 0, mon_sel = 0, mon_have = 0;
  logic mon_last;
  int mon_t;
  string mon_req;

  sc2_noise_channel dut_i (
    .clk(clk), .rst(rst), .psg_tick(psg_tick), .slow_tick(slow_tick),
    .chan_en(chan_en), .octave_sel(octave_sel), .div_reg(div_reg),
    .noise_sel(noise_sel), .alarm_sel(alarm_sel), .tone_in(tone_in),
    .ch_out(ch_out), .env_gate(env_gate)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Tick generators (off when the period is 0).
  always @(posedge clk) begin
    #1;
    if (tick_per > 0) psg_tick = (cyc % tick_per == 0);
    if (slow_per > 0) slow_tick = (cyc % slow_per == 0);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: measures intervals between output edges and compares them with the queue.
  always @(negedge clk) begin
    if (mon_en) begin
      logic v;
      v = mon_sel ? env_gate : ch_out;
      if (v !== mon_last) begin
        if (mon_have && exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check(cyc - mon_t == e, mon_req, "edge interval", cyc - mon_t, e);
        end
        mon_have = 1;
        mon_t = cyc;
      end
      mon_last = v;
    end
  end

  // Driver: pushes expected intervals and waits for the monitor to consume them.
  task automatic expect_intervals(input bit sel, input int iv, input int n,
                                  input string req);
    exp_q.delete();
    for (int i = 0; i < n; i++) exp_q.push_back(iv);
    mon_req = req;
    mon_sel = sel;
    mon_have = 0;
    mon_last = sel ? env_gate : ch_out;
    mon_en = 1;
    for (int k = 0; k < iv * (n + 3) + 20 && exp_q.size() > 0; k++) @(posedge clk);
    mon_en = 0;
    check(exp_q.size() == 0, req, "intervals left unseen", exp_q.size(), 0);
  endtask

  task automatic restart(input bit nz, input bit al, input bit oct, input logic [14:0] r);
    @(posedge clk); #2;
    chan_en = 0;
    noise_sel = nz; alarm_sel = al; octave_sel = oct; div_reg = r;
    repeat (2) @(posedge clk);
    #2 chan_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [14:0] q;
    int hi_seen;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    check(ch_out == 0, "R10", "ch_out after reset", ch_out, 0);
    check(env_gate == 0, "R10", "env_gate after reset", env_gate, 0);

    // R2/R3 tone: N=120 -> 8 steps, tick every 2 cycles -> 16 cycles.
    tick_per = 2;
    restart(0, 0, 0, {7'd120, 8'h00});
    expect_intervals(0, 16, 4, "R2");
    div_reg[7:0] = 8'hA5;                     // low bits must not matter (R2)
    expect_intervals(0, 16, 3, "R2");
    restart(0, 0, 0, {7'd127, 8'h00});
    expect_intervals(0, 2, 5, "R2");
    // R3 octave: N=124 -> 4 steps * 8 ticks * 2 cycles = 64.
    restart(0, 0, 1, {7'd124, 8'h00});
    expect_intervals(0, 64, 3, "R3");
    // R8: gate low in tone mode.
    hi_seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (env_gate) hi_seen++; end
    check(hi_seen == 0, "R8", "env_gate high cycles in tone mode", hi_seen, 0);

    // R4 noise against the polynomial model, with manual ticks.
    tick_per = 0;
    @(posedge clk); #2 psg_tick = 0;
    for (int pass = 0; pass < 2; pass++) begin
      restart(1, 0, 0, 15'h0000);
      q = 15'h0001;
      for (int i = 0; i < 40; i++) begin
        @(posedge clk); #2 psg_tick = 1;
        @(posedge clk); #2 psg_tick = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        q = {q[13:0], q[14] ^ q[13]};
        check(ch_out == q[0], "R4", "noise bit", ch_out, q[0]);
      end
      // R8 in noise mode
      check(env_gate == 0, "R8", "env_gate in noise mode", env_gate, 0);
    end

    // R6/R7 alarm: slow tick every 2 cycles, tone_in held high.
    slow_per = 2;
    tone_in = 1;
    restart(0, 1, 0, 15'b11);
    expect_intervals(1, 2, 6, "R6");
    restart(0, 1, 0, 15'b10);
    expect_intervals(1, 8, 4, "R6");
    restart(1, 1, 0, 15'b01);                 // noise bit set: still alarm (R1)
    expect_intervals(1, 16, 4, "R1");
    restart(0, 1, 0, 15'b00);
    expect_intervals(1, 64, 3, "R6");
    restart(0, 1, 0, 15'b10);
    expect_intervals(0, 8, 4, "R7");          // ch_out follows the envelope
    // R7: tone low -> silent while envelope runs.
    tone_in = 0;
    hi_seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (ch_out) hi_seen++; end
    check(hi_seen == 0, "R7", "ch_out high cycles with tone_in low", hi_seen, 0);
    tone_in = 1;
    repeat (10) @(posedge clk);

    // R9: disable silences within one cycle.
    @(posedge clk); #2 chan_en = 0;
    @(posedge clk); @(negedge clk);
    check(ch_out == 0, "R9", "ch_out after disable", ch_out, 0);
    check(env_gate == 0, "R9", "env_gate after disable", env_gate, 0);
    hi_seen = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (ch_out || env_gate) hi_seen++; end
    check(hi_seen == 0, "R9", "output activity while disabled", hi_seen, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule